// File: doc/BRIEF.md
# Global-History Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit state machines. Each lookup picks one of them with a selector built from a small branch index and the last H resolved or predicted branch directions, where H is 0, 1 or 2. With H history bits, every branch index owns 2^H counters. A pipeline front end issues a lookup with the branch index. One cycle later it gets back a registered guess and the exact selector that was used. The pipeline carries that selector down to the stage where the branch resolves. It hands the selector back with the real direction and a mispredict flag, and the block trains that same counter.

The history register works in one of two modes, chosen by a parameter. In the first mode it only moves when a branch resolves, and it takes in the actual direction. In the speculative mode it takes in the guessed direction at lookup time. A mispredict then rebuilds it from the history held in the returned selector, shifted with the real direction. A second parameter removes the branch index from the selector, so a single table line is shared by all branches and only the history chooses among its counters.

Top module: `ghist_dir_predictor`

## Requirements
- R1: After reset every counter holds 2'b10 (weak not-taken), the history is all zeros and the output valid flag is low. The first lookup therefore guesses not taken with a history field of zero.
- R2: A lookup accepted on one rising edge produces its guess on the next edge. The guess is taken exactly when bit 1 of the chosen counter is 0. The returned selector is {branch index, history}, with the history in the low H bits.
- R3: Counter encoding: 00 strong taken, 01 weak taken, 10 weak not-taken, 11 strong not-taken. A taken outcome steps the counter one place toward 00 and a not-taken outcome steps it one place toward 11, saturating at both ends.
- R4: A resolve trains the counter named by its selector, even when the live history has changed since that lookup.
- R5: Training one counter leaves every other counter unchanged, including the counters of other branch indices under the same history.
- R6: The history field holds the most recent direction in bit 0, and older directions move toward the upper bit.
- R7: In non-speculative mode a lookup never changes the history. Each resolve shifts in its actual direction, whatever the mispredict flag says.
- R8: In speculative mode each lookup shifts its own guessed direction into the history. A resolve without a mispredict leaves the history unchanged.
- R9: In speculative mode a resolve with the mispredict flag set loads the history with the history bits of its selector, shifted with the actual direction. This repair takes priority over a lookup in the same cycle.
- R10: When a lookup and a resolve hit the same counter in the same cycle, the lookup sees the value the counter held before the update.
- R11: With the index disabled, the branch index is ignored and the index field of the returned selector is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Lookup request this cycle |
| pred_idx | input | IDX_W | Branch index of the lookup |
| pred_out_valid | output | 1 | Registered: a guess is presented |
| pred_taken | output | 1 | Registered guess, 1 = taken |
| pred_sel | output | IDX_W+max(H,1) | Registered selector {index, history} that was used |
| res_valid | input | 1 | Resolve request this cycle |
| res_sel | input | IDX_W+max(H,1) | Selector returned unchanged from the lookup |
| res_taken | input | 1 | Actual direction, 1 = taken |
| res_mispred | input | 1 | The guess for this branch was wrong |

## Verification
The bench drives one counter through all four states and keeps pushing past both ends. A counter that wraps instead of saturating would flip its guess. It trains an entry while the live history differs from the returned selector. A design that indexed with the live history would train the wrong counter, and the expected guess would not appear. It fires a lookup and a resolve at the same counter in the same cycle, where a write-first table would return the trained value too early. In speculative mode it sends a mispredict repair alongside a lookup whose guess would shift in a different history value, so giving the lookup priority shows up in the next selector.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET     = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b00;
  localparam ctr_t CTR_STRONG_NT = 2'b11;

  function automatic logic ctr_says_taken(ctr_t c);
    return ~c[1];
  endfunction

endpackage

// File: rtl/ghp_ctr_step.sv
module ghp_ctr_step
  import ghp_pkg::*;
(
  input  ctr_t cur,
  input  logic outcome,
  output ctr_t nxt
);

  always_comb begin
    nxt = cur;
    if (outcome) begin
      if (cur != CTR_STRONG_T) nxt = cur - 2'd1;
    end else begin
      if (cur != CTR_STRONG_NT) nxt = cur + 2'd1;
    end
  end

endmodule

// File: rtl/ghp_ctr_table.sv
module ghp_ctr_table
  import ghp_pkg::*;
#(
  parameter int SEL_W = 6,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rd_sel,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_outcome
);

  ctr_t mem [DEPTH];
  ctr_t wr_cur;
  ctr_t wr_nxt;

  assign rd_ctr = mem[rd_sel];
  assign wr_cur = mem[wr_sel];

  ghp_ctr_step u_step (
    .cur     (wr_cur),
    .outcome (wr_outcome),
    .nxt     (wr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RESET;
    end else if (wr_en) begin
      mem[wr_sel] <= wr_nxt;
    end
  end

  // R3: a taken outcome never moves the entry toward not-taken
  assert_step_taken_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_outcome |=> mem[$past(wr_sel)] <= $past(wr_cur));

  // R3: a not-taken outcome never moves the entry toward taken
  assert_step_not_taken_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_outcome |=> mem[$past(wr_sel)] >= $past(wr_cur));

  assert_saturate_low_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_outcome && (wr_cur == CTR_STRONG_T)
      |=> mem[$past(wr_sel)] == CTR_STRONG_T);

  assert_saturate_high_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_outcome && (wr_cur == CTR_STRONG_NT)
      |=> mem[$past(wr_sel)] == CTR_STRONG_NT);

  // R5: an entry other than the one trained keeps its value
  assert_other_entry_kept_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en && (rd_sel != wr_sel) |=> mem[$past(rd_sel)] == $past(rd_ctr));

endmodule

// File: rtl/ghp_hist_reg.sv
module ghp_hist_reg #(
  parameter int HIST_W = 2,
  parameter bit SPEC   = 1'b0,
  localparam int HW    = (HIST_W == 0) ? 1 : HIST_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pred_fire,
  input  logic          pred_dir,
  input  logic          res_valid,
  input  logic          res_taken,
  input  logic          res_mispred,
  input  logic [HW-1:0] res_hist,
  output logic [HW-1:0] hist
);

  function automatic logic [HW-1:0] push(logic [HW-1:0] h, logic b);
    logic [HW:0] t;
    t = {h, b};
    return t[HW-1:0];
  endfunction

  generate
    if (HIST_W == 0) begin : g_no_hist
      assign hist = '0;
    end else begin : g_hist
      logic [HW-1:0] hist_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          hist_q <= '0;
        end else if (SPEC) begin
          if (res_valid && res_mispred) hist_q <= push(res_hist, res_taken);
          else if (pred_fire)           hist_q <= push(hist_q, pred_dir);
        end else if (res_valid) begin
          hist_q <= push(hist_q, res_taken);
        end
      end

      assign hist = hist_q;

      if (SPEC) begin : g_spec_chk
        // R8: speculative push of the guessed direction
        assert_spec_push_R8: assert property (@(posedge clk) disable iff (rst)
          pred_fire && !(res_valid && res_mispred) |=> hist_q[0] == $past(pred_dir));
        assert_no_push_on_hit_R8: assert property (@(posedge clk) disable iff (rst)
          !pred_fire && !(res_valid && res_mispred) |=> $stable(hist_q));
        // R9: repair takes the real direction
        assert_repair_R9: assert property (@(posedge clk) disable iff (rst)
          res_valid && res_mispred |=> hist_q[0] == $past(res_taken));
      end else begin : g_commit_chk
        // R7: history moves only on resolve
        assert_hist_idle_R7: assert property (@(posedge clk) disable iff (rst)
          !res_valid |=> $stable(hist_q));
        assert_hist_outcome_R7: assert property (@(posedge clk) disable iff (rst)
          res_valid |=> hist_q[0] == $past(res_taken));
      end
    end
  endgenerate

endmodule

// File: rtl/ghist_dir_predictor.sv
module ghist_dir_predictor
  import ghp_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int HIST_W    = 2,
  parameter bit SPEC_HIST = 1'b0,
  parameter bit USE_INDEX = 1'b1,
  localparam int HW       = (HIST_W == 0) ? 1 : HIST_W,
  localparam int SEL_W    = IDX_W + HW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pred_valid,
  input  logic [IDX_W-1:0] pred_idx,
  output logic             pred_out_valid,
  output logic             pred_taken,
  output logic [SEL_W-1:0] pred_sel,
  input  logic             res_valid,
  input  logic [SEL_W-1:0] res_sel,
  input  logic             res_taken,
  input  logic             res_mispred
);

  logic [HW-1:0]    hist;
  logic [IDX_W-1:0] idx_eff;
  logic [SEL_W-1:0] rd_sel;
  ctr_t             rd_ctr;
  logic             pred_dir;

  generate
    if (USE_INDEX) begin : g_index
      assign idx_eff = pred_idx;
    end else begin : g_single_line
      assign idx_eff = '0;
    end
  endgenerate

  assign rd_sel   = {idx_eff, hist};
  assign pred_dir = ctr_says_taken(rd_ctr);

  ghp_hist_reg #(
    .HIST_W (HIST_W),
    .SPEC   (SPEC_HIST)
  ) u_hist (
    .clk         (clk),
    .rst         (rst),
    .pred_fire   (pred_valid),
    .pred_dir    (pred_dir),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_mispred (res_mispred),
    .res_hist    (res_sel[HW-1:0]),
    .hist        (hist)
  );

  ghp_ctr_table #(
    .SEL_W (SEL_W)
  ) u_table (
    .clk        (clk),
    .rst        (rst),
    .rd_sel     (rd_sel),
    .rd_ctr     (rd_ctr),
    .wr_en      (res_valid),
    .wr_sel     (res_sel),
    .wr_outcome (res_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_out_valid <= 1'b0;
      pred_taken     <= 1'b0;
      pred_sel       <= '0;
    end else begin
      pred_out_valid <= pred_valid;
      if (pred_valid) begin
        pred_taken <= pred_dir;
        pred_sel   <= rd_sel;
      end
    end
  end

  assert_out_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> pred_out_valid);
  assert_out_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |=> !pred_out_valid);
  assert_sel_hist_R2: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> pred_sel[HW-1:0] == $past(hist));
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_out_valid);

  generate
    if (!USE_INDEX) begin : g_single_chk
      assert_index_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        pred_out_valid |-> pred_sel[SEL_W-1:HW] == '0);
    end
  endgenerate

endmodule

// File: tb/tb_ghist_dir_predictor.sv
module tb_ghist_dir_predictor;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 3;
  localparam int SW = IW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  // non-speculative, indexed
  logic          a_pv = 0, a_rv = 0, a_rt = 0, a_rm = 0;
  logic [IW-1:0] a_pidx = '0;
  logic [SW-1:0] a_rs = '0;
  logic          a_ov, a_pt;
  logic [SW-1:0] a_ps;

  // speculative, single line
  logic          s_pv = 0, s_rv = 0, s_rt = 0, s_rm = 0;
  logic [IW-1:0] s_pidx = '0;
  logic [SW-1:0] s_rs = '0;
  logic          s_ov, s_pt;
  logic [SW-1:0] s_ps;

  ghist_dir_predictor #(.IDX_W(IW), .HIST_W(2), .SPEC_HIST(1'b0), .USE_INDEX(1'b1)) dut (
    .clk(clk), .rst(rst), .pred_valid(a_pv), .pred_idx(a_pidx),
    .pred_out_valid(a_ov), .pred_taken(a_pt), .pred_sel(a_ps),
    .res_valid(a_rv), .res_sel(a_rs), .res_taken(a_rt), .res_mispred(a_rm));

  ghist_dir_predictor #(.IDX_W(IW), .HIST_W(2), .SPEC_HIST(1'b1), .USE_INDEX(1'b0)) dut_s (
    .clk(clk), .rst(rst), .pred_valid(s_pv), .pred_idx(s_pidx),
    .pred_out_valid(s_ov), .pred_taken(s_pt), .pred_sel(s_ps),
    .res_valid(s_rv), .res_sel(s_rs), .res_taken(s_rt), .res_mispred(s_rm));

  int n_vec = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic a_predict(input logic [IW-1:0] idx, output logic t, output logic [SW-1:0] sel);
    @(negedge clk); a_pv = 1; a_pidx = idx;
    @(negedge clk); a_pv = 0; t = a_pt; sel = a_ps;
  endtask

  task automatic a_resolve(input logic [SW-1:0] sel, input logic t);
    @(negedge clk); a_rv = 1; a_rs = sel; a_rt = t; a_rm = 1;
    @(negedge clk); a_rv = 0; a_rm = 0;
  endtask

  // set history to {older, newer} via a spare entry of index 7
  task automatic a_hist(input logic older, input logic newer);
    a_resolve({3'd7, 2'b00}, older);
    a_resolve({3'd7, 2'b00}, newer);
  endtask

  task automatic s_predict(input logic [IW-1:0] idx, output logic t, output logic [SW-1:0] sel);
    @(negedge clk); s_pv = 1; s_pidx = idx;
    @(negedge clk); s_pv = 0; t = s_pt; sel = s_ps;
  endtask

  task automatic s_resolve(input logic [SW-1:0] sel, input logic t, input logic m);
    @(negedge clk); s_rv = 1; s_rs = sel; s_rt = t; s_rm = m;
    @(negedge clk); s_rv = 0; s_rm = 0;
  endtask

  task automatic test_reset();
    logic t; logic [SW-1:0] s;
    check("R1 output valid low after reset", a_ov, 0);
    a_predict(3'd3, t, s);
    check("R1 first guess not taken", t, 0);
    check("R2 selector {3,00}", s, {3'd3, 2'b00});
  endtask

  task automatic test_counter();
    logic t; logic [SW-1:0] s;
    a_resolve({3'd3, 2'b00}, 1);                      // 10 -> 01
    a_hist(0, 0); a_predict(3'd3, t, s);
    check("R3 weak taken guesses taken", t, 1);
    check("R3 selector", s, {3'd3, 2'b00});
    a_resolve({3'd3, 2'b00}, 1);                      // 01 -> 00
    a_resolve({3'd3, 2'b00}, 1);                      // stays 00
    a_resolve({3'd3, 2'b00}, 0);                      // 00 -> 01
    a_hist(0, 0); a_predict(3'd3, t, s);
    check("R3 strong taken saturates then steps once", t, 1);
    a_resolve({3'd3, 2'b00}, 0);                      // 01 -> 10
    a_hist(0, 0); a_predict(3'd3, t, s);
    check("R3 weak taken to weak not-taken", t, 0);
    a_resolve({3'd3, 2'b00}, 0);                      // 11
    a_resolve({3'd3, 2'b00}, 0);                      // stays 11
    a_resolve({3'd3, 2'b00}, 1);                      // 10
    a_hist(0, 0); a_predict(3'd3, t, s);
    check("R3 strong not-taken saturates", t, 0);
  endtask

  task automatic test_history_commit();
    logic t; logic [SW-1:0] s;
    a_hist(1, 0);
    a_predict(3'd2, t, s);
    check("R6 newest outcome in bit 0", s, {3'd2, 2'b10});
    a_predict(3'd2, t, s);
    check("R7 lookup leaves history", s, {3'd2, 2'b10});
    a_resolve({3'd2, 2'b10}, 1);
    a_predict(3'd2, t, s);
    check("R6 shift after resolve", s, {3'd2, 2'b01});
    check("R7 entry 2/01 untouched", t, 0);
  endtask

  task automatic test_named_entry();
    logic t; logic [SW-1:0] s;
    a_resolve({3'd5, 2'b11}, 1);                      // live hist was 01
    a_predict(3'd5, t, s);
    check("R4 selector uses hist 11", s, {3'd5, 2'b11});
    check("R4 named entry trained", t, 1);
    a_predict(3'd4, t, s);
    check("R5 other index unaffected", t, 0);
    a_hist(0, 1);
    a_predict(3'd5, t, s);
    check("R4 live-history entry untouched", t, 0);
  endtask

  task automatic test_collision();
    logic t; logic [SW-1:0] s;
    a_hist(0, 0);
    @(negedge clk);
    a_pv = 1; a_pidx = 3'd6;
    a_rv = 1; a_rs = {3'd6, 2'b00}; a_rt = 1; a_rm = 1;
    @(negedge clk);
    a_pv = 0; a_rv = 0; a_rm = 0;
    check("R10 same-cycle lookup sees old value", a_pt, 0);
    check("R10 selector", a_ps, {3'd6, 2'b00});
    a_hist(0, 0);
    a_predict(3'd6, t, s);
    check("R10 update still applied", t, 1);
  endtask

  task automatic test_spec_push();
    logic t; logic [SW-1:0] s;
    s_predict(3'd5, t, s);
    check("R11 index ignored", s, 5'b00000);
    check("R1 spec first guess", t, 0);
    s_resolve(5'b00000, 1, 0);
    s_predict(3'd1, t, s);
    check("R8 correct resolve keeps history", s, 5'b00000);
    check("R8 trained guess taken", t, 1);
    s_predict(3'd7, t, s);
    check("R8 taken guess pushed", s, 5'b00001);
    s_predict(3'd3, t, s);
    check("R8 second push", s, 5'b00010);
    check("R8 guess from entry 10", t, 0);
  endtask

  task automatic test_spec_repair();
    logic t; logic [SW-1:0] s;
    s_resolve(5'b00010, 1, 1);                        // repair: push(10,1)=01
    s_predict(3'd2, t, s);
    check("R9 repaired history", s, 5'b00001);
    @(negedge clk);
    s_pv = 1; s_pidx = 3'd4;
    s_rv = 1; s_rs = 5'b00011; s_rt = 0; s_rm = 1;
    @(negedge clk);
    s_pv = 0; s_rv = 0; s_rm = 0;
    check("R9 lookup selector beside repair", s_ps, 5'b00010);
    check("R9 lookup guess beside repair", s_pt, 1);
    s_predict(3'd0, t, s);
    check("R9 repair wins over lookup push", s, 5'b00010);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    test_reset();
    test_counter();
    test_history_commit();
    test_named_entry();
    test_collision();
    test_spec_push();
    test_spec_repair();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

endmodule